// File: doc/BRIEF.md
# Addressable Asynchronous Serial Receiver

This block receives asynchronous serial frames on a single input line and places them into a two-entry receive queue. A frame starts with one low start bit. Eight data bits follow, least significant bit first. In nine-bit mode a ninth data bit comes next. The frame ends with one stop bit.

Each bit is oversampled by a baud tick. The tick comes from a down-counting divider clocked by the system clock, so one tick lasts `div_reload + 1` clocks. A speed select sets the number of ticks per bit to 16 or 64.

Each queue entry holds three things: the data byte, the ninth bit, and a framing-error flag for that frame. When nine-bit mode and address filtering are both on, a frame whose ninth bit is clear is dropped. This lets a node on a shared line ignore traffic until it sees an address frame. An overrun stops the receiver until software clears the receive enable.

The receive state machine has five states:

| State | Purpose | Transitions out |
|---|---|---|
| IDLE | Waits for a low line on a tick | to START when a low line is seen |
| START | Confirms the start bit | back to IDLE if the mid-bit vote reads high (glitch); to DATA at the end of the bit |
| DATA | Shifts in 8 or 9 bits | to STOP after the last data bit |
| STOP | Votes on the stop bit and completes the frame | to HALT if an accepted frame finds the queue full; otherwise to IDLE |
| HALT | Holds the receiver frozen after an overrun | leaves only when the receive enable clears |

From any state except HALT, a low port enable returns the machine to IDLE. A low receive enable returns it to IDLE from any state, including HALT.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, `rx_ready`, `irq` and `ovr_err` are all 0.
- R2: With `nine_bit`=0, a frame carries 8 data bits, least significant bit first. The byte appears on `rd_data`, and `rd_bit9` reads 0.
- R3: With `nine_bit`=1, the ninth received bit is stored with its byte and appears on `rd_bit9`.
- R4: With `nine_bit`=1 and `addr_det`=1, a frame whose ninth bit is 0 is dropped and leaves `rx_ready` at 0. A frame whose ninth bit is 1 is queued.
- R5: With `addr_det`=0, every frame is queued whatever its ninth bit.
- R6: A low stop-bit sample sets `rd_ferr` for that frame only. The next good frame reads `rd_ferr`=0.
- R7: The queue holds two frames and returns them oldest first. Pulsing `rd_en` for one clock removes the head entry.
- R8: If an accepted frame completes while both entries are full, `ovr_err` goes to 1 and the frame is lost. No later frame is queued, even after reads, until `rx_en` is cleared. Clearing `rx_en` clears `ovr_err` and keeps the queued frames.
- R9: `rx_ready` is 1 exactly when the queue holds a frame, and `irq` equals `rx_ready` AND `irq_en`.
- R10: No frame is received while `port_en` or `rx_en` is 0.
- R11: A low pulse that is gone by mid-bit is treated as a glitch and yields no frame.
- R12: One bit lasts 16 ticks when `hi_speed`=1 and 64 ticks when `hi_speed`=0. One tick lasts `div_reload`+1 clocks.
- R13: Each bit value is the majority of three samples on consecutive ticks around mid-bit, so one disturbed sample does not corrupt the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Serial port enable |
| rx_en | input | 1 | Receive enable; clearing it clears overrun |
| nine_bit | input | 1 | Nine data bits per frame when 1 |
| addr_det | input | 1 | Drops frames with ninth bit 0 when `nine_bit` is 1 |
| hi_speed | input | 1 | 16 ticks per bit when 1, 64 when 0 |
| div_reload | input | DIV_W | Divider reload value |
| irq_en | input | 1 | Interrupt enable |
| rxd | input | 1 | Serial input line, idle high |
| rd_en | input | 1 | Removes the head entry |
| rd_data | output | 8 | Head entry data byte |
| rd_bit9 | output | 1 | Head entry ninth bit |
| rd_ferr | output | 1 | Head entry framing error |
| ovr_err | output | 1 | Overrun flag |
| rx_ready | output | 1 | Queue not empty |
| irq | output | 1 | Receive interrupt |

## Verification
A wrong bit counter or phase counter shows up in the first frame. The byte read back is then shifted or has bits swapped, or `rx_ready` never rises, and either is visible one bit time after the stop bit. A lost HALT state or a stuck overrun flag shows on the frame that follows the overrun, through `rx_ready` and `ovr_err`. Queue pointer faults show up as reordered or repeated bytes within two reads. Filtering faults show as `rx_ready` rising on a frame whose ninth bit is 0.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HALT
    } rx_state_e;

    typedef struct packed {
        logic       ferr;
        logic       bit9;
        logic [7:0] data;
    } rx_frame_t;

endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == '0) begin
            cnt <= reload;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tick = run && (cnt == '0);

    // R12: with a nonzero reload, two ticks are never back to back
    assert_tick_spacing_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && reload != '0) |=> !tick);

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_frame_t din,
    input  logic      pop,
    output rx_frame_t dout,
    output logic      empty,
    output logic      full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    rx_frame_t       mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic [CW-1:0]   cnt;
    logic            do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == FULLC);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // R7: the producer never writes into a full queue
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R7: occupancy never exceeds the depth
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULLC);

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OSR_HI = 16,
    parameter int OSR_LO = 64
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      port_en,
    input  logic      rx_en,
    input  logic      nine_bit,
    input  logic      addr_det,
    input  logic      hi_speed,
    input  logic      tick,
    input  logic      rxd_s,
    input  logic      fifo_full,
    output logic      push,
    output rx_frame_t frame,
    output logic      ovr
);

    localparam int PH_W = $clog2(OSR_LO);
    localparam logic [PH_W-1:0] HI_LAST = PH_W'(OSR_HI - 1);
    localparam logic [PH_W-1:0] LO_LAST = PH_W'(OSR_LO - 1);
    localparam logic [PH_W-1:0] HI_MID  = PH_W'(OSR_HI / 2 + 1);
    localparam logic [PH_W-1:0] LO_MID  = PH_W'(OSR_LO / 2 + 1);

    rx_state_e       state, nxt;
    logic [PH_W-1:0] phase;
    logic [3:0]      bitcnt;
    logic [8:0]      sh;
    logic [1:0]      hist;
    logic            vote, at_mid, at_end, accept, run, done;
    logic [PH_W-1:0] last_ph, mid_ph;
    logic [3:0]      last_bit;

    assign run      = port_en && rx_en;
    assign last_ph  = hi_speed ? HI_LAST : LO_LAST;
    assign mid_ph   = hi_speed ? HI_MID : LO_MID;
    assign last_bit = nine_bit ? 4'd8 : 4'd7;
    assign vote     = (hist[1] & hist[0]) | (hist[1] & rxd_s) | (hist[0] & rxd_s);
    assign at_mid   = tick && (phase == mid_ph);
    assign at_end   = tick && (phase == last_ph);
    assign accept   = !(nine_bit && addr_det && !sh[8]);
    assign done     = (state == RX_STOP) && at_mid && accept;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (run && tick && !rxd_s) nxt = RX_START;
            RX_START: begin
                if (at_mid && vote) nxt = RX_IDLE;
                else if (at_end)    nxt = RX_DATA;
            end
            RX_DATA:  if (at_end && bitcnt == last_bit) nxt = RX_STOP;
            RX_STOP:  if (at_mid) nxt = (accept && fifo_full) ? RX_HALT : RX_IDLE;
            RX_HALT:  nxt = RX_HALT;
            default:  nxt = RX_IDLE;
        endcase
        if (!rx_en)                            nxt = RX_IDLE;
        else if (!port_en && state != RX_HALT) nxt = RX_IDLE;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase  <= '0;
            bitcnt <= '0;
            sh     <= '0;
            hist   <= 2'b11;
            ovr    <= 1'b0;
        end else begin
            if (tick) hist <= {hist[0], rxd_s};
            if (state == RX_IDLE)  phase <= PH_W'(1);
            else if (tick)         phase <= (phase == last_ph) ? '0 : phase + 1'b1;
            if (state != RX_DATA)  bitcnt <= '0;
            else if (at_end)       bitcnt <= bitcnt + 1'b1;
            if (state == RX_DATA && at_mid) sh[bitcnt] <= vote;
            if (!rx_en)                     ovr <= 1'b0;
            else if (done && fifo_full)     ovr <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        push       = done && !fifo_full && run;
        frame.data = sh[7:0];
        frame.bit9 = nine_bit & sh[8];
        frame.ferr = !vote;
    end

    // R4: nothing with a clear ninth bit is queued under filtering
    assert_addr_filter_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && nine_bit && addr_det) |-> frame.bit9);

    // R8: a frozen receiver never queues
    assert_halt_no_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_HALT) |-> !push);

    // R8: overrun stays set while reception stays enabled
    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && rx_en) |=> ovr);

    // R10: disabled port queues nothing
    assert_off_no_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |-> !push);

endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
    import uart_rx_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int DEPTH  = 2,
    parameter int OSR_HI = 16,
    parameter int OSR_LO = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_en,
    input  logic             rx_en,
    input  logic             nine_bit,
    input  logic             addr_det,
    input  logic             hi_speed,
    input  logic [DIV_W-1:0] div_reload,
    input  logic             irq_en,
    input  logic             rxd,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic             rd_bit9,
    output logic             rd_ferr,
    output logic             ovr_err,
    output logic             rx_ready,
    output logic             irq
);

    logic [1:0] sync;
    logic       tick, push, empty, full;
    rx_frame_t  wr_frame, head;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end

    uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (port_en && rx_en),
        .reload (div_reload),
        .tick   (tick)
    );

    uart_rx_core #(.OSR_HI(OSR_HI), .OSR_LO(OSR_LO)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_en   (port_en),
        .rx_en     (rx_en),
        .nine_bit  (nine_bit),
        .addr_det  (addr_det),
        .hi_speed  (hi_speed),
        .tick      (tick),
        .rxd_s     (sync[1]),
        .fifo_full (full),
        .push      (push),
        .frame     (wr_frame),
        .ovr       (ovr_err)
    );

    uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (wr_frame),
        .pop   (rd_en),
        .dout  (head),
        .empty (empty),
        .full  (full)
    );

    assign rd_data  = head.data;
    assign rd_bit9  = head.bit9;
    assign rd_ferr  = head.ferr;
    assign rx_ready = !empty;
    assign irq      = rx_ready && irq_en;

    // R9: interrupt only with a frame waiting
    assert_irq_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rx_ready);

endmodule

// File: tb/uart_addr_rx_tb.sv
module uart_addr_rx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0, rx_en = 1'b0, nine_bit = 1'b0, addr_det = 1'b0;
    logic       hi_speed = 1'b1, irq_en = 1'b0, rxd = 1'b1, rd_en = 1'b0;
    logic [7:0] div_reload = 8'd1;
    logic [7:0] rd_data;
    logic       rd_bit9, rd_ferr, ovr_err, rx_ready, irq;

    int total = 0;
    int bad = 0;
    int bc = 32;

    always #2.5 clk = ~clk;

    uart_addr_rx u_dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .rx_en(rx_en),
        .nine_bit(nine_bit), .addr_det(addr_det), .hi_speed(hi_speed),
        .div_reload(div_reload), .irq_en(irq_en), .rxd(rxd), .rd_en(rd_en),
        .rd_data(rd_data), .rd_bit9(rd_bit9), .rd_ferr(rd_ferr),
        .ovr_err(ovr_err), .rx_ready(rx_ready), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bit_clocks();
        return (hi_speed ? 16 : 64) * (int'(div_reload) + 1);
    endfunction

    task automatic send(input logic [8:0] v, input int nb, input logic stopv, input bit flip);
        bc = bit_clocks();
        @(negedge clk) rxd = 1'b0;
        repeat (bc) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rxd = v[i];
            if (flip) begin
                repeat (bc / 2) @(negedge clk);
                rxd = ~v[i];
                @(negedge clk);
                rxd = v[i];
                repeat (bc - bc / 2 - 1) @(negedge clk);
            end else begin
                repeat (bc) @(negedge clk);
            end
        end
        rxd = stopv;
        repeat (bc) @(negedge clk);
        rxd = 1'b1;
        repeat (bc) @(negedge clk);
    endtask

    task automatic pop_chk(input string req, input logic [7:0] d, input logic b9, input logic fe);
        @(negedge clk);
        chk(req, {31'd0, rx_ready}, 32'd1);
        chk(req, {24'd0, rd_data}, {24'd0, d});
        chk(req, {31'd0, rd_bit9}, {31'd0, b9});
        chk(req, {31'd0, rd_ferr}, {31'd0, fe});
        rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 ready", {31'd0, rx_ready}, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 ovr", {31'd0, ovr_err}, 0);
        rst_n = 1'b1;
        port_en = 1'b1;
        rx_en = 1'b1;
        repeat (10) @(negedge clk);

        // R2: 8-bit sweep, LSB first
        for (int v = 0; v < 256; v += 5) begin
            send(9'(v), 8, 1'b1, 1'b0);
            pop_chk("R2", 8'(v), 1'b0, 1'b0);
        end
        send(9'h0FF, 8, 1'b1, 1'b0);
        pop_chk("R2 ff", 8'hFF, 1'b0, 1'b0);

        // R3 / R5: nine-bit mode, filtering off
        nine_bit = 1'b1;
        send(9'h1A5, 9, 1'b1, 1'b0);
        pop_chk("R3 ninth set", 8'hA5, 1'b1, 1'b0);
        send(9'h05A, 9, 1'b1, 1'b0);
        pop_chk("R5 ninth clear kept", 8'h5A, 1'b0, 1'b0);

        // R4: address filtering
        addr_det = 1'b1;
        send(9'h033, 9, 1'b1, 1'b0);
        chk("R4 dropped", {31'd0, rx_ready}, 0);
        send(9'h1C3, 9, 1'b1, 1'b0);
        pop_chk("R4 address kept", 8'hC3, 1'b1, 1'b0);
        addr_det = 1'b0;
        nine_bit = 1'b0;

        // R6: framing error travels with its frame
        send(9'h066, 8, 1'b0, 1'b0);
        send(9'h099, 8, 1'b1, 1'b0);
        pop_chk("R6 ferr set", 8'h66, 1'b0, 1'b1);
        pop_chk("R6 ferr clear", 8'h99, 1'b0, 1'b0);

        // R9: interrupt gating
        send(9'h011, 8, 1'b1, 1'b0);
        @(negedge clk);
        chk("R9 irq off", {31'd0, irq}, 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk("R9 irq on", {31'd0, irq}, 1);
        pop_chk("R9 data", 8'h11, 1'b0, 1'b0);
        @(negedge clk);
        chk("R9 irq after drain", {31'd0, irq}, 0);
        irq_en = 1'b0;

        // R7 / R8: order, overrun, freeze, recovery
        send(9'h0A1, 8, 1'b1, 1'b0);
        send(9'h0B2, 8, 1'b1, 1'b0);
        chk("R7 no ovr at two", {31'd0, ovr_err}, 0);
        send(9'h0C3, 8, 1'b1, 1'b0);
        chk("R8 ovr set", {31'd0, ovr_err}, 1);
        pop_chk("R7 first", 8'hA1, 1'b0, 1'b0);
        pop_chk("R7 second", 8'hB2, 1'b0, 1'b0);
        chk("R8 third lost", {31'd0, rx_ready}, 0);
        send(9'h0D4, 8, 1'b1, 1'b0);
        chk("R8 frozen", {31'd0, rx_ready}, 0);
        chk("R8 ovr held", {31'd0, ovr_err}, 1);
        rx_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 ovr cleared", {31'd0, ovr_err}, 0);
        rx_en = 1'b1;
        repeat (3) @(negedge clk);
        send(9'h0E5, 8, 1'b1, 1'b0);
        pop_chk("R8 resumed", 8'hE5, 1'b0, 1'b0);

        // R10: disabled receiver
        port_en = 1'b0;
        send(9'h07E, 8, 1'b1, 1'b0);
        chk("R10 port off", {31'd0, rx_ready}, 0);
        port_en = 1'b1;
        rx_en = 1'b0;
        send(9'h07E, 8, 1'b1, 1'b0);
        chk("R10 rx off", {31'd0, rx_ready}, 0);
        rx_en = 1'b1;
        repeat (5) @(negedge clk);

        // R11: short low pulse is a glitch
        @(negedge clk) rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (64) @(negedge clk);
        chk("R11 glitch", {31'd0, rx_ready}, 0);
        send(9'h03C, 8, 1'b1, 1'b0);
        pop_chk("R11 after glitch", 8'h3C, 1'b0, 1'b0);

        // R12: 64x ratio and other divider values
        hi_speed = 1'b0;
        div_reload = 8'd1;
        send(9'h0C9, 8, 1'b1, 1'b0);
        pop_chk("R12 x64", 8'hC9, 1'b0, 1'b0);
        hi_speed = 1'b1;
        div_reload = 8'd2;
        send(9'h136, 9, 1'b1, 1'b0);
        pop_chk("R12 reload2", 8'h36, 1'b0, 1'b0);

        // R13: one disturbed sample per bit
        div_reload = 8'd0;
        repeat (5) @(negedge clk);
        for (int v = 1; v < 256; v += 37) begin
            send(9'(v), 8, 1'b1, 1'b1);
            pop_chk("R13 vote", 8'(v), 1'b0, 1'b0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule